// File: doc/BRIEF.md
# Bit-Level Serial ROM Responder

This block answers a two-wire serial bus master that toggles the clock and data lines one level at a time. Each time the master changes the lines it presents the new clock and data levels together with a one-cycle update strobe. The block keeps the levels from the previous update, and it detects start and stop conditions and clock rising edges from the old and new levels.

The block shifts in a control byte and then a word address, and it acknowledges each byte. Once the address byte is complete it fetches one byte from a 256-byte read-only table. When a later control byte asks for a read, the next eight clock rises carry that byte out, most significant bit first. The shift-out uses the same eight-bit phase that receives the next address, so a read returns the byte fetched by the previous transaction.

The table is computed from two parameters. Byte 63 holds a checksum of the 63 bytes below it. The returned data level idles high whenever the block is not pulling the line low.

Top module: `twowire_rom_resp`

## Requirements
- R1: After reset `sda_out` is 1, no acknowledge is pending and the bit counter is 0.
- R2: If `scl_in` is 1 in both the previous and the new update and `sda_in` differs from the stored level, the update is a bus condition. A 1-to-0 change is a start: it sets the bit counter to 1 and clears the control byte. A 0-to-1 change is a stop and changes nothing except the stored levels.
- R3: While the counter is 0 and no acknowledge is pending, every update other than a start is ignored. `sda_out` then just mirrors the new `sda_in`, and no acknowledge is ever driven.
- R4: A bit is taken only on an update where `scl_in` rises from 0 to 1 and `sda_in` equals the stored data level. A rise that changes the data level together with the clock is dropped and does not advance the counter.
- R5: Counts 1 to 8 shift the control byte in MSB first. After the eighth bit an acknowledge is pending, and the next clock rise drives `sda_out` to 0 and clears it. Bit 0 of the control byte is 1 for read and 0 for write.
- R6: Counts 9 to 16 shift the word address in MSB first. For a read control byte, each of these rises drives `sda_out` from bit 7 of the data register, which then shifts left. For a write control byte, `sda_out` mirrors `sda_in`.
- R7: On the eighth address bit the data register loads the table byte at the newly completed address, an acknowledge becomes pending and the counter returns to 0. The counter never exceeds 16.
- R8: Table byte i (i not 63) is (i*STEP + BASE) mod 256, with defaults STEP=29 and BASE=53. Byte 63 is the sum of bytes 0 to 62 mod 256.
- R9: `sda_out` changes only on an update. On any update in which the block does not drive, it equals the new `sda_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd | input | 1 | One-cycle strobe: new line levels are valid |
| scl_in | input | 1 | New clock line level |
| sda_in | input | 1 | New data line level |
| sda_out | output | 1 | Data level returned to the master |

## Verification
The bench sends a full byte with no start first; a design that left its idle state without a start would drive an acknowledge there. It inserts a rise that moves clock and data together right before an address byte; a design that counted that rise would acknowledge one bit early and capture the wrong address. It restarts in the middle of a control byte; a design that did not reset its counter on a start would acknowledge at the wrong position. It reads back the checksum byte, the top byte and two other bytes, and it sends a write-phase address whose bits differ from the held data; a design that drove data during a write, or that fetched from the address before the last bit, would return the wrong bit values.

// File: rtl/twowire_rom_resp.sv
module twowire_rom_resp #(
  parameter int unsigned STEP = 29,
  parameter int unsigned BASE = 53
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out
);
  localparam int unsigned SUM_IDX = 63;

  function automatic logic [7:0] fill(input int unsigned i);
    return 8'((i * STEP + BASE) % 256);
  endfunction

  function automatic logic [7:0] sum_low();
    logic [7:0] s = 8'd0;
    for (int unsigned i = 0; i < SUM_IDX; i++) s = s + fill(i);
    return s;
  endfunction

  localparam logic [7:0] CSUM = sum_low();

  function automatic logic [7:0] rom(input logic [7:0] a);
    return (a == 8'(SUM_IDX)) ? CSUM : fill(int'(a));
  endfunction

  logic       scl_q, sda_q, ack;
  logic [4:0] cnt;
  logic [7:0] cmd, addr, dat;

  logic       n_sda, n_ack;
  logic [4:0] n_cnt;
  logic [7:0] n_cmd, n_addr, n_dat;

  wire cond   = scl_q && scl_in && (sda_q != sda_in);
  wire rise   = !scl_q && scl_in;
  wire [7:0] addr_nx = {addr[6:0], sda_in};

  assign sda_out = sda_q;

  always_comb begin
    n_sda  = sda_in;
    n_ack  = ack;
    n_cnt  = cnt;
    n_cmd  = cmd;
    n_addr = addr;
    n_dat  = dat;
    if (cond) begin
      if (!sda_in) begin
        n_cnt = 5'd1;
        n_cmd = 8'd0;
      end
    end else if (cnt == 5'd0 && !ack) begin
      n_cnt = cnt;
    end else if (rise) begin
      if (ack) begin
        n_sda = 1'b0;
        n_ack = 1'b0;
      end else if (sda_q == sda_in) begin
        if (cnt < 5'd9) begin
          n_cmd = {cmd[6:0], sda_in};
          n_cnt = 5'(cnt + 5'd1);
          if (cnt == 5'd8) n_ack = 1'b1;
        end else if (cnt < 5'd17) begin
          if (cmd[0]) n_sda = dat[7];
          n_addr = addr_nx;
          n_dat  = {dat[6:0], 1'b0};
          n_cnt  = 5'(cnt + 5'd1);
          if (cnt == 5'd16) begin
            n_dat = rom(addr_nx);
            n_ack = 1'b1;
            n_cnt = 5'd0;
          end
        end else begin
          n_sda = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      ack   <= 1'b0;
      cnt   <= 5'd0;
      cmd   <= 8'd0;
      addr  <= 8'd0;
      dat   <= 8'd0;
    end else if (upd) begin
      scl_q <= scl_in;
      sda_q <= n_sda;
      ack   <= n_ack;
      cnt   <= n_cnt;
      cmd   <= n_cmd;
      addr  <= n_addr;
      dat   <= n_dat;
    end
  end
endmodule

module twowire_rom_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd,
  input logic       scl_in,
  input logic       sda_in,
  input logic       sda_out,
  input logic       scl_q,
  input logic       ack,
  input logic [4:0] cnt,
  input logic [7:0] cmd
);
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && scl_q && scl_in && sda_out && !sda_in) |=> (cnt == 5'd1 && cmd == 8'd0));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cnt == 5'd0 && !ack && !(scl_q && scl_in && sda_out && !sda_in)) |=> (cnt == 5'd0));

  a_r5_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ack && !scl_q && scl_in) |=> (!sda_out && !ack));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd16);

  a_r9_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(sda_out));

  a_r9_low_clock_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !scl_in) |=> (sda_out == $past(sda_in)));
endmodule

bind twowire_rom_resp twowire_rom_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .scl_in(scl_in), .sda_in(sda_in),
  .sda_out(sda_out), .scl_q(scl_q), .ack(ack), .cnt(cnt), .cmd(cmd)
);

// File: tb/twowire_rom_resp_test.sv
module twowire_rom_resp_test;
  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0, scl = 1'b1, sda = 1'b1;
  logic sda_out;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  twowire_rom_resp uut (.clk(clk), .rst_n(rst_n), .upd(upd), .scl_in(scl), .sda_in(sda), .sda_out(sda_out));

  function automatic logic [7:0] mem_of(input int a);
    logic [7:0] s = 8'd0;
    if (a != 63) return 8'((a * 29 + 53) % 256);
    for (int i = 0; i < 63; i++) s = s + 8'((i * 29 + 53) % 256);
    return s;
  endfunction

  initial begin
    item_t it;
    forever begin
      wait (sbq.size() != 0);
      it = sbq.pop_front();
      checks++;
      if (sda_out !== it.exp) begin
        fails++;
        $display("FAIL %s: sda_out=%0b expected %0b", it.tag, sda_out, it.exp);
      end
    end
  end

  task automatic step(input logic c, input logic d, input bit chk, input logic e, input string tag);
    @(negedge clk);
    scl = c; sda = d; upd = 1'b1;
    @(posedge clk); #1;
    upd = 1'b0;
    if (chk) sbq.push_back('{e, tag});
  endtask

  task automatic bit_out(input logic b, input logic e, input string tag);
    step(1'b0, b, 1'b1, b, {tag, " low"});
    step(1'b1, b, 1'b1, e, tag);
  endtask

  task automatic start_c();
    step(1'b0, 1'b1, 1'b0, 1'b0, "");
    step(1'b1, 1'b1, 1'b0, 1'b0, "");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R2 start");
    step(1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic send_byte(input logic [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) bit_out(v[i], v[i], tag);
  endtask

  task automatic ack_bit(input logic e, input string tag);
    bit_out(1'b1, e, tag);
  endtask

  task automatic read_byte(input logic [7:0] master, input logic [7:0] expd, input string tag);
    for (int i = 7; i >= 0; i--) bit_out(master[i], expd[7 - (7 - i)], tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (sda_out !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: sda_out=%0b expected 1", sda_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (sda_out !== 1'b1) begin
      fails++;
      $display("FAIL R1 after release: sda_out=%0b expected 1", sda_out);
    end

    // R3: a whole byte plus an acknowledge clock without a start
    send_byte(8'hA0, "R3 idle bit");
    ack_bit(1'b1, "R3 no ack while idle");
    step(1'b0, 1'b0, 1'b0, 1'b0, "");
    step(1'b1, 1'b0, 1'b0, 1'b0, "");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R2 stop");

    // R5 write control byte, R4 glitch rise, R6/R7 address 0x3F
    start_c();
    send_byte(8'hA0, "R5 ctrl bit");
    ack_bit(1'b0, "R5 ctrl ack");
    step(1'b0, 1'b0, 1'b0, 1'b0, "");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R4 dropped rise");
    send_byte(8'h3F, "R4 R6 write addr mirror");
    ack_bit(1'b0, "R7 addr ack");

    // R8 checksum byte read, then fetch from 0xFF
    start_c();
    send_byte(8'hA1, "R5 read ctrl");
    ack_bit(1'b0, "R5 read ack");
    read_byte(8'hFF, mem_of(63), "R8 checksum bit");
    ack_bit(1'b0, "R7 ack after read");

    // R6 read of byte 0xFF while sending address 0x10
    start_c();
    send_byte(8'hA1, "R5 read ctrl");
    ack_bit(1'b0, "R5 read ack");
    read_byte(8'h10, mem_of(255), "R6 byte FF bit");
    ack_bit(1'b0, "R7 ack after read");

    // R2 restart in the middle of a control byte
    start_c();
    bit_out(1'b1, 1'b1, "R2 partial");
    bit_out(1'b0, 1'b0, "R2 partial");
    bit_out(1'b1, 1'b1, "R2 partial");
    step(1'b0, 1'b1, 1'b0, 1'b0, "");
    step(1'b1, 1'b1, 1'b0, 1'b0, "");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R2 restart");
    step(1'b0, 1'b0, 1'b0, 1'b0, "");
    send_byte(8'hA1, "R2 ctrl after restart");
    ack_bit(1'b0, "R2 ack after restart");
    read_byte(8'hFF, mem_of(16), "R7 byte 10 bit");
    ack_bit(1'b0, "R7 ack");

    // R6 write control: address phase must not drive held data (byte FF)
    start_c();
    send_byte(8'hA0, "R5 ctrl bit");
    ack_bit(1'b0, "R5 ctrl ack");
    send_byte(8'h55, "R6 write no drive");
    ack_bit(1'b0, "R7 addr ack");
    start_c();
    send_byte(8'hA1, "R5 read ctrl");
    ack_bit(1'b0, "R5 read ack");
    read_byte(8'h00, mem_of(85), "R8 byte 55 bit");
    ack_bit(1'b0, "R7 ack");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R9 mirror low");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R9 idle rise");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R9 stop mirror");

    wait (sbq.size() == 0);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule